// File: doc/BRIEF.md
# Periodic IQ Power Meter

This block measures the mean-square power of a complex baseband stream. Each accepted I/Q pair contributes I squared plus Q squared to a wide accumulator. A measurement window holds a programmable number of pairs. When the window is full, the sum is copied into a result register and a one-cycle interrupt is raised. The host then reads the result and divides by the window length if it wants an average.

Measurement is armed by a sync pulse. After the sync, a programmable number of valid samples (a count of groups of eight) is skipped, and then the first window opens. From that point a free-running period counter reopens a fresh window every P valid samples. Between the end of one window and the start of the next the accumulator does nothing. The window length and the period are 21-bit values. Each arrives on the configuration inputs as a 16-bit low word and a 5-bit high word.

Top module: `iq_power_meter`

## Requirements
- R1: The result of a window equals the sum, over its N accepted pairs, of I*I + Q*Q, where I and Q are two's-complement signed samples.
- R2: The window length N is {cnt_hi_i, cnt_lo_i} and the period P is {per_hi_i, per_lo_i}. The high word supplies bits 16 to 20 of each. N must be at least 1 and P must be greater than N.
- R3: After a sync, the first 8*D valid samples are skipped, where D is dly_i. Sample 8*D+1 is the first sample of the first window. The sample presented in the sync cycle itself is never used.
- R4: Counting from the start of a window, valid sample P+1 opens the next window with the accumulator cleared. This repeats without a further sync.
- R5: On the clock edge that takes in a window's Nth sample, the result is updated and the interrupt goes high for exactly one cycle, visible after that edge.
- R6: The result holds its value between completions. It never changes in a cycle where the interrupt is low.
- R7: Cycles with the valid input low are ignored. They advance no counter and add nothing.
- R8: A sync aborts any window or delay in progress and restarts the delay countdown. A sync in the same cycle as a window's last sample wins: no interrupt is raised and the result is unchanged.
- R9: Reset clears the result and the interrupt. Before the first sync, no window runs and no interrupt occurs.
- R10: The accumulator is 54 bits wide. Windows whose sums exceed 32 bits, for example full-scale negative samples, are reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Arms the meter and restarts the delay |
| smp_valid_i | input | 1 | Qualifies the sample pair |
| smp_i_i | input | 16 | In-phase sample, signed |
| smp_q_i | input | 16 | Quadrature sample, signed |
| cnt_lo_i | input | 16 | Window length, low word |
| cnt_hi_i | input | 5 | Window length, high word |
| per_lo_i | input | 16 | Restart period, low word |
| per_hi_i | input | 5 | Restart period, high word |
| dly_i | input | 9 | Start delay in groups of eight valid samples |
| pwr_result_o | output | 54 | Power sum of the last completed window |
| pwr_irq_o | output | 1 | One-cycle completion pulse |

## Verification
The two events that can land in the same cycle are a sync and the last sample of a window. The bench provokes this by raising sync together with the valid flag of the Nth pair. It judges the outcome by an interrupt that stays low, a result that keeps its old value, and a correct sum for the fresh window that follows. The second pairing is a window restart right after a completion. The minimum legal period (N=1, P=2) exercises it and must give alternating completions.

// File: rtl/iq_pm_pkg.sv
package iq_pm_pkg;
  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_DELAY = 2'd1,
    PM_RUN   = 2'd2
  } pm_state_e;
endpackage

// File: rtl/iq_pm_rst_sync.sv
module iq_pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/iq_pm_square.sv
module iq_pm_square #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] din,
  output logic        [2*DATA_W-1:0] sq
);
  logic signed [2*DATA_W-1:0] prod;

  always_comb begin
    prod = din * din;
    sq   = prod;
  end
endmodule

// File: rtl/iq_pm_seq.sv
module iq_pm_seq
  import iq_pm_pkg::*;
#(
  parameter int CNT_W     = 21,
  parameter int DLY_W     = 9,
  parameter int DLY_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] win_len,
  input  logic [CNT_W-1:0] period,
  input  logic [DLY_W-1:0] dly,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             win_last
);
  localparam int DC_W = DLY_W + DLY_SHIFT;

  pm_state_e        st_q, st_nx;
  logic [DC_W-1:0]  dly_q, dly_nx;
  logic [CNT_W-1:0] per_q, per_nx;
  logic [CNT_W-1:0] win_q, win_nx;
  logic             on_q, on_nx;
  logic [DC_W-1:0]  dly_load;
  logic [CNT_W-1:0] per_inc, win_inc;
  logic             upd_en;

  assign dly_load = {dly, {DLY_SHIFT{1'b0}}};
  assign per_inc  = per_q + CNT_W'(1);
  assign win_inc  = win_q + CNT_W'(1);
  assign upd_en   = sync_i | valid_i;

  always_comb begin
    st_nx    = st_q;
    dly_nx   = dly_q;
    per_nx   = per_q;
    win_nx   = win_q;
    on_nx    = on_q;
    acc_clr  = 1'b0;
    acc_en   = 1'b0;
    win_last = 1'b0;
    if (sync_i) begin
      acc_clr = 1'b1;
      per_nx  = '0;
      win_nx  = '0;
      dly_nx  = dly_load;
      if (dly_load == '0) begin
        st_nx = PM_RUN;
        on_nx = 1'b1;
      end else begin
        st_nx = PM_DELAY;
        on_nx = 1'b0;
      end
    end else if (valid_i) begin
      case (st_q)
        PM_DELAY: begin
          dly_nx = dly_q - DC_W'(1);
          if (dly_q == DC_W'(1)) begin
            st_nx = PM_RUN;
            on_nx = 1'b1;
          end
        end
        PM_RUN: begin
          if (on_q) begin
            acc_en = 1'b1;
            win_nx = win_inc;
            if (win_inc == win_len) begin
              win_last = 1'b1;
              on_nx    = 1'b0;
            end
          end
          if (per_inc == period) begin
            per_nx  = '0;
            win_nx  = '0;
            on_nx   = 1'b1;
            acc_clr = 1'b1;
          end else begin
            per_nx = per_inc;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PM_IDLE;
      dly_q <= '0;
      per_q <= '0;
      win_q <= '0;
      on_q  <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_nx;
      dly_q <= dly_nx;
      per_q <= per_nx;
      win_q <= win_nx;
      on_q  <= on_nx;
    end
  end
endmodule

// File: rtl/iq_pm_accum.sv
module iq_pm_accum #(
  parameter int PWR_W = 33,
  parameter int ACC_W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_clr,
  input  logic             acc_en,
  input  logic             win_last,
  input  logic [PWR_W-1:0] pwr,
  output logic [ACC_W-1:0] result_o,
  output logic             irq_o
);
  logic [ACC_W-1:0] acc_q, acc_nx;
  logic [ACC_W-1:0] res_q;
  logic [ACC_W-1:0] sum;
  logic             irq_q;
  logic             acc_we;

  assign sum    = acc_q + ACC_W'(pwr);
  assign acc_we = acc_en | acc_clr;

  always_comb begin
    acc_nx = acc_q;
    if (acc_en)  acc_nx = sum;
    if (acc_clr) acc_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= win_last;
      if (acc_we)   acc_q <= acc_nx;
      if (win_last) res_q <= sum;
    end
  end

  assign result_o = res_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/iq_power_meter.sv
module iq_power_meter #(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 21,
  parameter int LO_W      = 16,
  parameter int DLY_W     = 9,
  parameter int DLY_SHIFT = 3,
  localparam int HI_W     = CNT_W - LO_W,
  localparam int PWR_W    = 2 * DATA_W + 1,
  localparam int ACC_W    = PWR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_i_i,
  input  logic [DATA_W-1:0] smp_q_i,
  input  logic [LO_W-1:0]   cnt_lo_i,
  input  logic [HI_W-1:0]   cnt_hi_i,
  input  logic [LO_W-1:0]   per_lo_i,
  input  logic [HI_W-1:0]   per_hi_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [ACC_W-1:0]  pwr_result_o,
  output logic              pwr_irq_o
);
  localparam int LANES = 2;

  logic                               rst_n_sync;
  logic [LANES-1:0][DATA_W-1:0]       lane_in;
  logic [LANES-1:0][2*DATA_W-1:0]     lane_sq;
  logic [PWR_W-1:0]                   pwr;
  logic                               acc_clr, acc_en, win_last;

  iq_pm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign lane_in[0] = smp_i_i;
  assign lane_in[1] = smp_q_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_pm_square #(.DATA_W(DATA_W)) u_sq (
      .din (lane_in[g]),
      .sq  (lane_sq[g])
    );
  end

  assign pwr = PWR_W'(lane_sq[0]) + PWR_W'(lane_sq[1]);

  iq_pm_seq #(
    .CNT_W     (CNT_W),
    .DLY_W     (DLY_W),
    .DLY_SHIFT (DLY_SHIFT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .sync_i   (sync_i),
    .valid_i  (smp_valid_i),
    .win_len  ({cnt_hi_i, cnt_lo_i}),
    .period   ({per_hi_i, per_lo_i}),
    .dly      (dly_i),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .win_last (win_last)
  );

  iq_pm_accum #(
    .PWR_W (PWR_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .win_last (win_last),
    .pwr      (pwr),
    .result_o (pwr_result_o),
    .irq_o    (pwr_irq_o)
  );
endmodule

// File: rtl/iq_pm_chk.sv
module iq_pm_chk #(
  parameter int ACC_W = 54
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             valid_i,
  input logic             win_last,
  input logic             irq,
  input logic [ACC_W-1:0] result
);
  // R5: completion pulse lasts one cycle
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: sequencer's last-sample flag becomes an interrupt on the next cycle
  a_r5_last_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> irq);

  // R6: result changes only together with the interrupt
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> irq);

  // R7: an idle cycle never produces a completion
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !irq);

  // R8: sync takes priority over a completion
  a_r8_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !irq);
endmodule

bind iq_power_meter iq_pm_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .sync_i   (sync_i),
  .valid_i  (smp_valid_i),
  .win_last (win_last),
  .irq      (pwr_irq_o),
  .result   (pwr_result_o)
);

// File: tb/iq_power_meter_tb.sv
module iq_power_meter_tb;
  typedef struct packed {
    int dly; int n; int p; int a; int sa; int b; int sb; int gap; int nwin;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{0, 5,     9,     100,    3,  -50,    7,   0, 3},
    '{2, 4,     7,     -1000,  13, 2000,   -11, 1, 3},
    '{1, 1,     2,     300,    -1, 5,      2,   0, 4},
    '{0, 8,     12,    -32768, 0,  -32768, 0,   0, 2},
    '{0, 65538, 65540, 7,      0,  -3,     0,   0, 1}
  };

  logic clk = 1'b0;
  logic rst_n, sync, vld;
  logic signed [15:0] si, sq;
  logic [15:0] cnt_lo, per_lo;
  logic [4:0]  cnt_hi, per_hi;
  logic [8:0]  dly;
  logic [53:0] result;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iq_power_meter u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync), .smp_valid_i(vld),
    .smp_i_i(si), .smp_q_i(sq), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
    .per_lo_i(per_lo), .per_hi_i(per_hi), .dly_i(dly),
    .pwr_result_o(result), .pwr_irq_o(irq)
  );

  function automatic longint pw(logic signed [15:0] x, logic signed [15:0] y);
    return longint'(x) * longint'(x) + longint'(y) * longint'(y);
  endfunction

  task automatic check(string req, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int n, int p);
    dly    = 9'(d);
    cnt_lo = 16'(n);
    cnt_hi = 5'(n >> 16);
    per_lo = 16'(p);
    per_hi = 5'(p >> 16);
  endtask

  task automatic run_vec(vec_t v, int idx);
    longint acc = 0, pend_val = 0, last_res;
    bit pend = 0, stray = 0;
    int d8 = v.dly * 8;
    int k = 0;
    int total = d8 + (v.nwin - 1) * v.p + v.n;
    int cyc = 0;
    set_cfg(v.dly, v.n, v.p);
    @(negedge clk);
    last_res = longint'(result);
    sync = 1; vld = 0;
    @(negedge clk);
    sync = 0;
    while (k < total || pend) begin
      // observe outcome of the previous cycle
      if (pend) begin
        // R1 R5: sum and pulse on the completing sample
        check($sformatf("R1/R5 vec%0d", idx), irq && longint'(result) == pend_val,
              longint'(result), pend_val);
        last_res = pend_val;
        pend = 0;
      end else if (irq || longint'(result) != last_res) begin
        stray = 1;
      end
      if (k >= total) break;
      cyc++;
      if (v.gap != 0 && (cyc % 3) == 2) begin
        vld = 0;  // R7: idle cycle
      end else begin
        k++;
        vld = 1;
        si = 16'(v.a + v.sa * k);
        sq = 16'(v.b + v.sb * k);
        if (k > d8) begin
          int r = k - d8 - 1;
          int pos = r % v.p;
          if (pos == 0) acc = 0;
          if (pos < v.n) begin
            acc += pw(si, sq);
            if (pos == v.n - 1) begin pend = 1; pend_val = acc; end
          end
        end
      end
      @(negedge clk);
      vld = 0;
    end
    // R3 R4 R6: no stray pulse or result change across delay, gaps and restarts
    check($sformatf("R6 hold vec%0d", idx), !stray, longint'(stray), 0);
  endtask

  initial begin
    rst_n = 0; sync = 0; vld = 0; si = 0; sq = 0;
    set_cfg(0, 3, 5);
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset result", result == 0, longint'(result), 0);
    check("R9 reset irq", irq == 0, longint'(irq), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R9: no measurement without sync
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin
        vld = 1; si = 16'(i * 50); sq = 16'(-i);
        @(negedge clk);
        if (irq) seen = 1;
      end
      vld = 0;
      check("R9 no sync no irq", !seen, longint'(seen), 0);
    end
    // table walk: R1 R2 R3 R4 R5 R6 R7 R10 (vec3 is full scale for R10, vec4 uses high words for R2)
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // R8: sync collides with the last sample of a window
    begin
      longint prev, exp_sum = 0;
      set_cfg(0, 4, 10);
      @(negedge clk);
      sync = 1;
      @(negedge clk);
      sync = 0;
      prev = longint'(result);
      for (int i = 1; i <= 3; i++) begin
        vld = 1; si = 16'(i * 200); sq = 16'(i * 7);
        @(negedge clk);
      end
      sync = 1; vld = 1; si = 16'(999); sq = 16'(999);
      @(negedge clk);
      sync = 0; vld = 0;
      check("R8 collision irq", irq == 0, longint'(irq), 0);
      check("R8 collision result", longint'(result) == prev, longint'(result), prev);
      for (int i = 1; i <= 4; i++) begin
        vld = 1; si = 16'(-i * 300); sq = 16'(i * 11);
        exp_sum += pw(si, sq);
        @(negedge clk);
      end
      vld = 0;
      check("R8 restart sum", irq && longint'(result) == exp_sum, longint'(result), exp_sum);
    end
    // R9: reset in mid-window clears result
    begin
      sync = 1;
      @(negedge clk);
      sync = 0; vld = 1; si = 16'(5); sq = 16'(5);
      @(negedge clk);
      vld = 0; rst_n = 0;
      @(negedge clk);
      check("R9 mid reset", result == 0 && irq == 0, longint'(result), 0);
      rst_n = 1;
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule